// File: doc/BRIEF.md
# ALU Shifter and Flag Unit

This block is the last combinational stage behind an 8-bit ALU. It takes the raw ALU result and can pass it through, move it one place right, or move it one place left, and it derives the four condition flags (zero, overflow, negative, carry) for the status register. It has no clock and no state.

A single carry value is chosen by a 2-bit carry select from four sources: the stored carry from the status register, a constant 0, a constant 1, or the adder's carry-out. That value does two jobs. It is the bit shifted into the vacant end during a shift, and it is the carry flag when no shift is done. As a result, one shift code gives a rotate through carry, a zero-filling shift or a one-filling shift, depending on the carry select. The remaining shift code forces the result bus to zero.

The overflow flag is computed at all times from the sign bits of both operands and the sign of the unshifted result. The operand sign bits come from the ALU inputs, with the right operand already inverted for a subtract. Zero and negative are taken from the final bus after the shift stage.

Top module: `alu_shift_flags`

## Requirements
- R1: With shift select 2'b00, `result_o` equals `alu_result_i` and `carry_o` equals the selected carry value.
- R2: Carry select picks the selected carry value: 2'b00 takes `status_carry_i`, 2'b01 gives 0, 2'b10 gives 1, and 2'b11 takes `adder_cout_i`.
- R3: With shift select 2'b01 (right), `result_o` is `{c, alu_result_i[7:1]}` and `carry_o` is `alu_result_i[0]`, where c is the selected carry value.
- R4: With shift select 2'b10 (left), `result_o` is `{alu_result_i[6:0], c}` and `carry_o` is `alu_result_i[7]`, where c is the selected carry value.
- R5: With shift select 2'b11, `result_o` is all zeros and `carry_o` is 0, whatever the other inputs are.
- R6: `neg_o` equals bit 7 of `result_o`, the bus after the shift stage, for every shift code.
- R7: `zero_o` is 1 exactly when all eight bits of `result_o` are 0. This includes shift code 2'b11, where it is always 1.
- R8: `ovf_o` is 1 exactly when `lhs_msb_i` equals `rhs_msb_i` and `alu_result_i[7]` differs from them. The shift select has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_result_i | input | 8 | Raw result from the ALU |
| adder_cout_i | input | 1 | Carry-out of the adder |
| lhs_msb_i | input | 1 | Bit 7 of the left operand |
| rhs_msb_i | input | 1 | Bit 7 of the right operand, after any subtract inversion |
| status_carry_i | input | 1 | Carry bit held in the status register |
| shift_sel_i | input | 2 | 00 none, 01 right, 10 left, 11 force zero |
| carry_sel_i | input | 2 | 00 status carry, 01 zero, 10 one, 11 adder carry |
| result_o | output | 8 | Final result bus |
| zero_o | output | 1 | Result is all zeros |
| ovf_o | output | 1 | Two's-complement overflow |
| neg_o | output | 1 | Sign bit of the result |
| carry_o | output | 1 | Carry flag |

## Verification
The hardest cases to reach are the ones where the shift changes the answer given by the unshifted result. One is a one-bit operand such as 0x01 shifted right with a zero fill: the zero flag turns on although the ALU result was not zero. Another is 0x80 shifted left with fill 0: the result is zero and the carry flag is 1. A third is a shift that changes bit 7, so the negative flag no longer matches the sign used for overflow. The directed tasks build these operands for each shift direction and each fill source. A sweep then runs every combination of shift and carry select codes over the corner operands 0x00, 0x01, 0x7F, 0x80 and 0xFF, and over random values, with all operand sign combinations.

// File: rtl/alu_sf_pkg.sv
package alu_sf_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SH_NONE  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_VOID  = 2'b11
    } shift_e;

    typedef enum logic [1:0] {
        CS_STATUS = 2'b00,
        CS_ZERO   = 2'b01,
        CS_ONE    = 2'b10,
        CS_ADDER  = 2'b11
    } csel_e;

    typedef struct packed {
        logic [DATA_W-1:0] bus;
        logic              carry;
    } shift_res_t;

endpackage

// File: rtl/alu_sf_carry_mux.sv
module alu_sf_carry_mux
    import alu_sf_pkg::*;
(
    input  logic [1:0] carry_sel_i,
    input  logic       status_carry_i,
    input  logic       adder_cout_i,
    output logic       carry_d_o
);

    always_comb begin
        unique case (csel_e'(carry_sel_i))
            CS_STATUS: carry_d_o = status_carry_i;
            CS_ZERO:   carry_d_o = 1'b0;
            CS_ONE:    carry_d_o = 1'b1;
            CS_ADDER:  carry_d_o = adder_cout_i;
            default:   carry_d_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_sf_shifter.sv
module alu_sf_shifter
    import alu_sf_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [1:0]       shift_sel_i,
    input  logic             fill_i,
    output logic [WIDTH-1:0] bus_d_o,
    output logic             carry_d_o
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] right_d;
    logic [WIDTH-1:0] left_d;

    // each lane takes its neighbour; the vacant end lane takes the fill
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        if (g == MSB) begin : g_top
            assign right_d[g] = fill_i;
        end else begin : g_rmid
            assign right_d[g] = data_i[g+1];
        end
        if (g == 0) begin : g_bot
            assign left_d[g] = fill_i;
        end else begin : g_lmid
            assign left_d[g] = data_i[g-1];
        end
    end

    always_comb begin
        unique case (shift_e'(shift_sel_i))
            SH_NONE: begin
                bus_d_o   = data_i;
                carry_d_o = fill_i;
            end
            SH_RIGHT: begin
                bus_d_o   = right_d;
                carry_d_o = data_i[0];
            end
            SH_LEFT: begin
                bus_d_o   = left_d;
                carry_d_o = data_i[MSB];
            end
            default: begin
                bus_d_o   = '0;
                carry_d_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_sf_flags.sv
module alu_sf_flags #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bus_i,
    input  logic             raw_msb_i,
    input  logic             lhs_msb_i,
    input  logic             rhs_msb_i,
    output logic             zero_d_o,
    output logic             neg_d_o,
    output logic             ovf_d_o
);

    localparam int MSB = WIDTH - 1;

    always_comb begin
        zero_d_o = ~(|bus_i);
        neg_d_o  = bus_i[MSB];
        // operands agree in sign, unshifted result disagrees
        ovf_d_o  = (lhs_msb_i ~^ rhs_msb_i) & (raw_msb_i ^ lhs_msb_i);
    end

endmodule

// File: rtl/alu_shift_flags.sv
module alu_shift_flags
    import alu_sf_pkg::*;
(
    input  logic [7:0] alu_result_i,
    input  logic       adder_cout_i,
    input  logic       lhs_msb_i,
    input  logic       rhs_msb_i,
    input  logic       status_carry_i,
    input  logic [1:0] shift_sel_i,
    input  logic [1:0] carry_sel_i,
    output logic [7:0] result_o,
    output logic       zero_o,
    output logic       ovf_o,
    output logic       neg_o,
    output logic       carry_o
);

    localparam int MSB = DATA_W - 1;

    logic       fill_d;
    shift_res_t shr_d;
    logic       zero_d;
    logic       neg_d;
    logic       ovf_d;

    alu_sf_carry_mux u_cmux (
        .carry_sel_i    (carry_sel_i),
        .status_carry_i (status_carry_i),
        .adder_cout_i   (adder_cout_i),
        .carry_d_o      (fill_d)
    );

    alu_sf_shifter #(.WIDTH(DATA_W)) u_shift (
        .data_i      (alu_result_i),
        .shift_sel_i (shift_sel_i),
        .fill_i      (fill_d),
        .bus_d_o     (shr_d.bus),
        .carry_d_o   (shr_d.carry)
    );

    alu_sf_flags #(.WIDTH(DATA_W)) u_flags (
        .bus_i     (shr_d.bus),
        .raw_msb_i (alu_result_i[MSB]),
        .lhs_msb_i (lhs_msb_i),
        .rhs_msb_i (rhs_msb_i),
        .zero_d_o  (zero_d),
        .neg_d_o   (neg_d),
        .ovf_d_o   (ovf_d)
    );

    assign result_o = shr_d.bus;
    assign carry_o  = shr_d.carry;
    assign zero_o   = zero_d;
    assign neg_o    = neg_d;
    assign ovf_o    = ovf_d;

    always_comb begin
        if (!$isunknown({alu_result_i, shift_sel_i, carry_sel_i,
                         status_carry_i, adder_cout_i, lhs_msb_i, rhs_msb_i})) begin
            if (shift_sel_i == 2'b00)
                AST_PASS_THROUGH: assert (result_o == alu_result_i && carry_o == fill_d); // R1
            if (carry_sel_i == 2'b01)
                AST_FORCED_LOW: assert (fill_d == 1'b0); // R2
            if (carry_sel_i == 2'b10)
                AST_FORCED_HIGH: assert (fill_d == 1'b1); // R2
            if (shift_sel_i == 2'b01)
                AST_RIGHT_MOVE: assert (result_o[MSB] == fill_d && carry_o == alu_result_i[0]); // R3
            if (shift_sel_i == 2'b10)
                AST_LEFT_MOVE: assert (result_o[0] == fill_d && carry_o == alu_result_i[MSB]); // R4
            if (shift_sel_i == 2'b11)
                AST_VOID_CLEAR: assert (result_o == '0 && !carry_o && zero_o); // R5
            AST_ZERO_NOT_NEG: assert (!(zero_o && neg_o)); // R6
            if (zero_o)
                AST_ZERO_BUS: assert ($countones(result_o) == 0); // R7
            if (ovf_o)
                AST_OVF_SIGNS: assert (lhs_msb_i == rhs_msb_i && alu_result_i[MSB] != lhs_msb_i); // R8
        end
    end

endmodule

// File: tb/tb_alu_shift_flags.sv
module tb_alu_shift_flags;

    logic       clk = 1'b0;
    logic [7:0] alu_result_i = 8'h00;
    logic       adder_cout_i = 1'b0;
    logic       lhs_msb_i = 1'b0;
    logic       rhs_msb_i = 1'b0;
    logic       status_carry_i = 1'b0;
    logic [1:0] shift_sel_i = 2'b00;
    logic [1:0] carry_sel_i = 2'b00;
    logic [7:0] result_o;
    logic       zero_o, ovf_o, neg_o, carry_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alu_shift_flags dut (
        .alu_result_i   (alu_result_i),
        .adder_cout_i   (adder_cout_i),
        .lhs_msb_i      (lhs_msb_i),
        .rhs_msb_i      (rhs_msb_i),
        .status_carry_i (status_carry_i),
        .shift_sel_i    (shift_sel_i),
        .carry_sel_i    (carry_sel_i),
        .result_o       (result_o),
        .zero_o         (zero_o),
        .ovf_o          (ovf_o),
        .neg_o          (neg_o),
        .carry_o        (carry_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] d, input logic [1:0] sh, input logic [1:0] cs,
                         input logic sc, input logic ac, input logic l7, input logic r7);
        @(negedge clk);
        alu_result_i = d; shift_sel_i = sh; carry_sel_i = cs;
        status_carry_i = sc; adder_cout_i = ac; lhs_msb_i = l7; rhs_msb_i = r7;
        #2;
    endtask

    // reference built from the requirement text
    task automatic model_check(input string tag);
        logic       c;
        logic [7:0] eb;
        logic       ec;
        string      rq;
        case (carry_sel_i)
            2'b00: c = status_carry_i;
            2'b01: c = 1'b0;
            2'b10: c = 1'b1;
            default: c = adder_cout_i;
        endcase
        case (shift_sel_i)
            2'b00: begin eb = alu_result_i; ec = c; rq = "R1"; end
            2'b01: begin eb = {c, alu_result_i[7:1]}; ec = alu_result_i[0]; rq = "R3"; end
            2'b10: begin eb = {alu_result_i[6:0], c}; ec = alu_result_i[7]; rq = "R4"; end
            default: begin eb = 8'h00; ec = 1'b0; rq = "R5"; end
        endcase
        chk({rq, " ", tag}, "result", int'(result_o), int'(eb));
        chk({rq, " ", tag}, "carry", int'(carry_o), int'(ec));
        chk({"R6 ", tag}, "neg", int'(neg_o), int'(eb[7]));
        chk({"R7 ", tag}, "zero", int'(zero_o), int'(eb == 8'h00));
        chk({"R8 ", tag}, "ovf", int'(ovf_o),
            int'(lhs_msb_i == rhs_msb_i && alu_result_i[7] != lhs_msb_i));
    endtask

    task automatic t_idle;
        #2;
        chk("R7 idle", "zero", int'(zero_o), 1);
        chk("R1 idle", "result", int'(result_o), 0);
        chk("R8 idle", "ovf", int'(ovf_o), 0);
    endtask

    task automatic t_pass;
        apply(8'hA5, 2'b00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R1", "result", int'(result_o), 'hA5);
        chk("R1", "carry", int'(carry_o), 1);
        chk("R6", "neg", int'(neg_o), 1);
    endtask

    task automatic t_carry_sel;
        apply(8'h10, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 status", "carry", int'(carry_o), 1);
        apply(8'h10, 2'b00, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R2 zero", "carry", int'(carry_o), 0);
        apply(8'h10, 2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 one", "carry", int'(carry_o), 1);
        apply(8'h10, 2'b00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R2 adder", "carry", int'(carry_o), 1);
        apply(8'h10, 2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R2 adder", "carry", int'(carry_o), 0);
    endtask

    task automatic t_right;
        apply(8'h01, 2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R3 zfill", "result", int'(result_o), 'h00);
        chk("R3 zfill", "carry", int'(carry_o), 1);
        chk("R7 zfill", "zero", int'(zero_o), 1);
        apply(8'h02, 2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R3 rotate", "result", int'(result_o), 'h81);
        chk("R6 rotate", "neg", int'(neg_o), 1);
        apply(8'h00, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R3 onefill", "result", int'(result_o), 'h80);
    endtask

    task automatic t_left;
        apply(8'h80, 2'b10, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1);
        chk("R4 zfill", "result", int'(result_o), 'h00);
        chk("R4 zfill", "carry", int'(carry_o), 1);
        chk("R7 zfill", "zero", int'(zero_o), 1);
        apply(8'h40, 2'b10, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4 adderfill", "result", int'(result_o), 'h81);
        chk("R4 adderfill", "carry", int'(carry_o), 0);
        apply(8'h7F, 2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 onefill", "result", int'(result_o), 'hFF);
    endtask

    task automatic t_void;
        apply(8'hFF, 2'b11, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R5", "result", int'(result_o), 0);
        chk("R5", "carry", int'(carry_o), 0);
        chk("R7 void", "zero", int'(zero_o), 1);
        chk("R8 void", "ovf", int'(ovf_o), 1);
    endtask

    task automatic t_overflow;
        apply(8'h80, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 pos", "ovf", int'(ovf_o), 1);
        apply(8'h7F, 2'b00, 2'b01, 1'b0, 1'b0, 1'b1, 1'b1);
        chk("R8 neg", "ovf", int'(ovf_o), 1);
        apply(8'h80, 2'b00, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8 mixed", "ovf", int'(ovf_o), 0);
        apply(8'h80, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 shifted", "ovf", int'(ovf_o), 1);
    endtask

    task automatic t_sweep;
        logic [7:0] corners [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
        for (int i = 0; i < 45; i++) begin
            logic [7:0] d;
            d = (i < 5) ? corners[i] : 8'($urandom);
            for (int sh = 0; sh < 4; sh++)
                for (int cs = 0; cs < 4; cs++)
                    for (int m = 0; m < 16; m++) begin
                        apply(d, 2'(sh), 2'(cs), m[0], m[1], m[2], m[3]);
                        model_check("sweep");
                    end
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected <150000", cyc);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

    initial begin
        t_idle();
        t_pass();
        t_carry_sel();
        t_right();
        t_left();
        t_void();
        t_overflow();
        t_sweep();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule